// File: doc/BRIEF.md
# Prioritized 32-Line Interrupt Controller

This block collects 32 level-sensitive interrupt request lines, one per peripheral, and hands one of them at a time to a processor. Each request is latched into a pending bit. A per-line enable masks it. A combinational arbiter then picks the most urgent enabled pending line, and the block offers it through a valid / line-number / acknowledge handshake. Software reaches the block through a word-addressed write port with a combinational read path. Pending bits and enable bits each have a write-one-to-set address and a write-one-to-clear address. The priority fields sit in eight 32-bit words, four lines to a word.

Each line carries a two-bit priority, and a lower value is more urgent. When the processor acknowledges, the offered line leaves the pending set and is pushed onto an active stack. While a line is active, only a strictly more urgent candidate is offered, so interrupts nest. A one-cycle end-of-service pulse pops the most recently activated line. If that line's request is still high at that moment, its pending bit is set again.

The stack is controlled by a small state machine with three states. STK_EMPTY means no line is active. STK_NESTED means one or more lines are active and there is room for more. STK_FULL means every priority level has an active entry. The transitions are PUSH (acknowledge), POP (end of service) and SWAP (both in the same cycle, which keeps the depth unchanged). The next state always follows from the post-update depth.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending, enable, active and priority state is zero, every readable word reads 0, and `irq_valid` is low.
- R2: A write to word 0 sets the pending bits where the data has ones, and a write to word 1 clears them. Both words read the 32 pending bits.
- R3: A write to word 2 sets the enable bits where the data has ones, and a write to word 3 clears them. Both words read the 32 enable bits.
- R4: Words 8 to 15 hold the priorities. Line i uses word 8 + i/4, bits [8*(i%4)+7 : 8*(i%4)+6], and all other bits of these words read as zero.
- R5: A request that is high at a clock edge sets that line's pending bit unless the line is active. The bit stays set after the request drops.
- R6: `irq_valid` is high when some enabled pending line is eligible. `irq_line` then names the one with the lowest priority value, and the lowest line number wins a tie.
- R7: The selection is recomputed every cycle. A more urgent request that arrives before acknowledge replaces the line being offered in the cycle after its pending bit is set.
- R8: `irq_ack` while `irq_valid` is high clears the offered line's pending bit and marks it active. Word 4 reads the active-line bitmap.
- R9: While lines are active, a candidate is offered only if its priority value is strictly lower than that of the most recently activated line.
- R10: An `irq_done` pulse retires the most recently activated line. With no active line it has no effect.
- R11: A request that stays high while its line is active does not set pending. It sets pending at the edge where its service ends.
- R12: `irq_ack` (with valid) and `irq_done` in the same cycle retire the top line first, then activate the offered line.
- R13: Writes to words 5, 6 and 7 change nothing, and those words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 32 | Level request lines, one per peripheral |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_valid | output | 1 | A line is being offered |
| irq_line | output | 5 | Number of the offered line |
| irq_ack | input | 1 | Processor takes the offered line |
| irq_done | input | 1 | End-of-service pulse for the most recent active line |

## Verification
The hardest state to reach from the ports is a stack that is more than one level deep, because each level needs its own priority. Reaching it takes priorities that strictly decrease, raised in the right order, and an acknowledge each time. The same holds for an acknowledge and an end of service landing in the same cycle on a non-empty stack. Directed sequences program distinct priorities first, then raise pending lines from least to most urgent and acknowledge each one in turn. A long random phase follows, with frequent acknowledges, sparse end-of-service pulses and random priority writes, and a behavioural queue model is compared against the ports on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Register word addresses
    localparam int unsigned A_PEND_SET  = 0;
    localparam int unsigned A_PEND_CLR  = 1;
    localparam int unsigned A_EN_SET    = 2;
    localparam int unsigned A_EN_CLR    = 3;
    localparam int unsigned A_ACTIVE    = 4;
    localparam int unsigned A_PRIO_BASE = 8;

    // Active-stack controller states
    typedef enum logic [1:0] {
        STK_EMPTY,
        STK_NESTED,
        STK_FULL
    } stk_state_e;

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int LINE_W    = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_LINES-1:0]             irq_req,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata,
    input  logic                             ack_fire,
    input  logic [LINE_W-1:0]                ack_line,
    input  logic [NUM_LINES-1:0]             act_now,
    input  logic [NUM_LINES-1:0]             act_next,
    output logic [NUM_LINES-1:0]             pend_q,
    output logic [NUM_LINES-1:0]             en_q,
    output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q
);

    localparam int PER_REG  = DATA_W / 8;
    localparam int PRIO_REGS = NUM_LINES / PER_REG;

    logic                 wr_pset, wr_pclr, wr_eset, wr_eclr;
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] ack_clr;
    logic [NUM_LINES-1:0] req_set;

    assign wbits   = wdata[NUM_LINES-1:0];
    assign wr_pset = we && (addr == ADDR_W'(A_PEND_SET));
    assign wr_pclr = we && (addr == ADDR_W'(A_PEND_CLR));
    assign wr_eset = we && (addr == ADDR_W'(A_EN_SET));
    assign wr_eclr = we && (addr == ADDR_W'(A_EN_CLR));
    assign ack_clr = ack_fire ? (NUM_LINES'(1) << ack_line) : '0;
    assign req_set = irq_req & ~act_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~(wr_pclr ? wbits : '0) & ~ack_clr)
                    | (wr_pset ? wbits : '0) | req_set;
            en_q   <= (en_q | (wr_eset ? wbits : '0)) & ~(wr_eclr ? wbits : '0);
        end
    end

    // One priority field per line, in the top bits of its byte
    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
            localparam int WORD = i / PER_REG;
            localparam int BYTE = i % PER_REG;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prio_q[i] <= '0;
                end else if (we && (addr == ADDR_W'(A_PRIO_BASE + WORD))) begin
                    prio_q[i] <= wdata[8*BYTE+7 -: PRIO_W];
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_PEND_SET) || addr == ADDR_W'(A_PEND_CLR)) begin
            rdata = DATA_W'(pend_q);
        end else if (addr == ADDR_W'(A_EN_SET) || addr == ADDR_W'(A_EN_CLR)) begin
            rdata = DATA_W'(en_q);
        end else if (addr == ADDR_W'(A_ACTIVE)) begin
            rdata = DATA_W'(act_now);
        end else begin
            for (int j = 0; j < PRIO_REGS; j++) begin
                if (addr == ADDR_W'(A_PRIO_BASE + j)) begin
                    for (int k = 0; k < PER_REG; k++) begin
                        rdata[8*k+7 -: PRIO_W] = prio_q[j*PER_REG+k];
                    end
                end
            end
        end
    end

    // R3
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eclr |=> ((en_q & $past(wbits)) == '0));

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pset |=> ((pend_q & $past(wbits)) == $past(wbits)));

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    parameter int LINE_W    = 5
) (
    input  logic [NUM_LINES-1:0]             cand,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    input  logic                             ceil_valid,
    input  logic [PRIO_W-1:0]                ceil_prio,
    output logic                             sel_valid,
    output logic [LINE_W-1:0]                sel_line,
    output logic [PRIO_W-1:0]                sel_prio
);

    logic found;

    // Walk downward with <=, so the lowest index wins among equals
    always_comb begin
        found    = 1'b0;
        sel_line = '0;
        sel_prio = '1;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio[i] <= sel_prio)) begin
                found    = 1'b1;
                sel_line = LINE_W'(i);
                sel_prio = prio[i];
            end
        end
        sel_valid = found && (!ceil_valid || sel_prio < ceil_prio);
    end

endmodule

// File: rtl/pic_active_stack.sv
module pic_active_stack
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    parameter int LINE_W    = 5,
    parameter int DEPTH     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [LINE_W-1:0]    push_line,
    input  logic [PRIO_W-1:0]    push_prio,
    input  logic                 pop_req,
    output logic                 top_valid,
    output logic [PRIO_W-1:0]    top_prio,
    output logic [NUM_LINES-1:0] act_now,
    output logic [NUM_LINES-1:0] act_next
);

    localparam int DW = $clog2(DEPTH + 1);

    stk_state_e        state_q, state_n;
    logic [DW-1:0]     depth_q, base, depth_n;
    logic              pop;
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [PRIO_W-1:0] prio_q [DEPTH];

    assign pop     = pop_req && (state_q != STK_EMPTY);
    assign base    = depth_q - DW'(pop);
    assign depth_n = base + DW'(push);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STK_EMPTY;
            depth_q <= '0;
        end else begin
            state_q <= state_n;
            depth_q <= depth_n;
        end
    end

    // Next state: PUSH, POP or SWAP
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            STK_EMPTY: begin
                if (push) state_n = (depth_n == DW'(DEPTH)) ? STK_FULL : STK_NESTED;
            end
            STK_NESTED: begin
                if (depth_n == '0)             state_n = STK_EMPTY;
                else if (depth_n == DW'(DEPTH)) state_n = STK_FULL;
            end
            STK_FULL: begin
                if (depth_n == '0)             state_n = STK_EMPTY;
                else if (depth_n != DW'(DEPTH)) state_n = STK_NESTED;
            end
            default: state_n = STK_EMPTY;
        endcase
    end

    // Entry storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                line_q[j] <= '0;
                prio_q[j] <= '0;
            end
        end else if (push) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (DW'(j) == base) begin
                    line_q[j] <= push_line;
                    prio_q[j] <= push_prio;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        top_valid = (state_q != STK_EMPTY);
        top_prio  = '0;
        act_now   = '0;
        act_next  = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (DW'(j) == depth_q - DW'(1)) top_prio = prio_q[j];
            if (DW'(j) < depth_q)           act_now  |= NUM_LINES'(1) << line_q[j];
            if (DW'(j) < base)              act_next |= NUM_LINES'(1) << line_q[j];
        end
        if (push) act_next |= NUM_LINES'(1) << push_line;
    end

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DW'(DEPTH));

    // R10
    pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push && state_q != STK_EMPTY) |=> (depth_q == $past(depth_q) - DW'(1)));

    // R10
    state_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == STK_EMPTY) == (depth_q == '0));

    // R9
    generate
        for (genvar j = 0; j < DEPTH - 1; j++) begin : g_order
            nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (depth_q > DW'(j + 1)) |-> (prio_q[j+1] < prio_q[j]));
        end
    endgenerate

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int LEVELS   = 1 << PRIO_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_valid,
    output logic [LINE_W-1:0]    irq_line,
    input  logic                 irq_ack,
    input  logic                 irq_done
);

    logic [NUM_LINES-1:0]             pend_q, en_q, act_now, act_next;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
    logic                             ack_fire, top_valid;
    logic [PRIO_W-1:0]                top_prio, sel_prio;

    assign ack_fire = irq_ack && irq_valid;

    pic_regs #(
        .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .LINE_W(LINE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .ack_fire(ack_fire), .ack_line(irq_line),
        .act_now(act_now), .act_next(act_next),
        .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q)
    );

    pic_arbiter #(
        .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)
    ) u_arb (
        .cand(pend_q & en_q), .prio(prio_q),
        .ceil_valid(top_valid), .ceil_prio(top_prio),
        .sel_valid(irq_valid), .sel_line(irq_line), .sel_prio(sel_prio)
    );

    pic_active_stack #(
        .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W), .DEPTH(LEVELS)
    ) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(ack_fire), .push_line(irq_line), .push_prio(sel_prio),
        .pop_req(irq_done),
        .top_valid(top_valid), .top_prio(top_prio),
        .act_now(act_now), .act_next(act_next)
    );

    // R6
    offer_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (pend_q[irq_line] && en_q[irq_line]));

    // R8
    ack_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> act_now[$past(irq_line)]);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] b_req = '0;
    logic        b_we = 1'b0;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        irq_valid;
    logic [4:0]  irq_line;
    logic        b_ack = 1'b0;
    logic        b_done = 1'b0;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(b_req),
        .reg_we(b_we), .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(rdata),
        .irq_valid(irq_valid), .irq_line(irq_line),
        .irq_ack(b_ack), .irq_done(b_done)
    );

    // Behavioural reference model
    bit m_pend[32];
    bit m_en[32];
    int m_prio[32];
    int stk_line[$];
    int stk_prio[$];

    function automatic void m_reset();
        for (int i = 0; i < 32; i++) begin
            m_pend[i] = 0; m_en[i] = 0; m_prio[i] = 0;
        end
        stk_line.delete();
        stk_prio.delete();
    endfunction

    function automatic void m_pick(output bit v, output int ln, output int p);
        int best = 4;
        ln = 0;
        for (int i = 0; i < 32; i++)
            if (m_pend[i] && m_en[i] && m_prio[i] < best) begin
                best = m_prio[i]; ln = i;
            end
        p = best;
        v = (best < 4) && (stk_prio.size() == 0 || best < stk_prio[$]);
    endfunction

    function automatic logic [31:0] m_active();
        logic [31:0] m = '0;
        foreach (stk_line[j]) m[stk_line[j]] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = '0;
        if (a == 0 || a == 1) for (int i = 0; i < 32; i++) r[i] = m_pend[i];
        else if (a == 2 || a == 3) for (int i = 0; i < 32; i++) r[i] = m_en[i];
        else if (a == 4) r = m_active();
        else if (a >= 8) for (int k = 0; k < 4; k++) r[8*k+6 +: 2] = 2'(m_prio[(a-8)*4+k]);
        return r;
    endfunction

    function automatic void m_step();
        bit v; int ln, p;
        logic [31:0] act;
        int a = int'(b_addr);
        m_pick(v, ln, p);
        if (b_done && stk_line.size() > 0) begin
            void'(stk_line.pop_back()); void'(stk_prio.pop_back());
        end
        if (b_ack && v) begin
            stk_line.push_back(ln); stk_prio.push_back(p);
        end
        act = m_active();
        for (int i = 0; i < 32; i++) begin
            bit np = m_pend[i];
            if (b_we && a == 1 && b_wdata[i]) np = 0;
            if (b_ack && v && i == ln) np = 0;
            if (b_we && a == 0 && b_wdata[i]) np = 1;
            if (b_req[i] && !act[i]) np = 1;
            m_pend[i] = np;
            if (b_we && a == 2 && b_wdata[i]) m_en[i] = 1;
            if (b_we && a == 3 && b_wdata[i]) m_en[i] = 0;
        end
        if (b_we && a >= 8)
            for (int k = 0; k < 4; k++) m_prio[(a-8)*4+k] = int'(b_wdata[8*k+6 +: 2]);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare();
        bit v; int ln, p;
        m_pick(v, ln, p);
        chk(cur_req, 32'(irq_valid), 32'(v));
        if (v) chk(cur_req, 32'(irq_line), 32'(ln));
        chk(cur_req, rdata, m_read(int'(b_addr)));
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) m_step();
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; b_req = '0; b_we = 0; b_ack = 0; b_done = 0; b_addr = '0;
        repeat (2) @(posedge clk);
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        b_we = 1; b_addr = 4'(a); b_wdata = d;
        tick();
        b_we = 0;
    endtask

    task automatic rd(int a, string req, logic [31:0] exp);
        b_addr = 4'(a);
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic pulse_ack();
        b_ack = 1; tick(); b_ack = 0;
    endtask

    task automatic pulse_done();
        b_done = 1; tick(); b_done = 0;
    endtask

    task automatic all_low_urgency();
        for (int r = 8; r < 16; r++) wr(r, 32'hC0C0C0C0);
        wr(2, 32'hFFFFFFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        for (int a = 0; a < 16; a++) rd(a, "R1", 32'h0);
        chk("R1", 32'(irq_valid), 32'h0);

        // R4 priority field layout
        cur_req = "R4";
        wr(8, 32'hFFFFFFFF);
        rd(8, "R4", 32'hC0C0C0C0);
        wr(9, 32'h00400080);
        rd(9, "R4", 32'h00400080);

        // R3 enables
        cur_req = "R3";
        wr(2, 32'h000000F0);
        wr(3, 32'h00000030);
        rd(3, "R3", 32'h000000C0);

        // R2 pending
        cur_req = "R2";
        wr(0, 32'h00000081);
        rd(1, "R2", 32'h00000081);
        wr(1, 32'h00000080);
        rd(0, "R2", 32'h00000001);

        // R5 request latches
        do_reset();
        cur_req = "R5";
        wr(2, 32'hFFFFFFFF);
        b_req = 32'h20; tick(); b_req = '0; tick();
        rd(0, "R5", 32'h20);
        chk("R6", 32'(irq_line), 32'd5);

        // R6 priority and tie order
        do_reset();
        cur_req = "R6";
        all_low_urgency();
        wr(8, 32'h80C0C0C0);
        wr(10, 32'hC040C0C0);
        wr(13, 32'hC0C0C040);
        wr(0, 32'h80100408);
        chk("R6", 32'(irq_line), 32'd10);
        wr(1, 32'h00000400);
        chk("R6", 32'(irq_line), 32'd20);

        // R7 late arrival
        cur_req = "R7";
        wr(14, 32'hC0C000C0);
        b_req = 32'h02000000; tick(); b_req = '0;
        chk("R7", 32'(irq_valid), 32'h1);
        chk("R7", 32'(irq_line), 32'd25);

        // R8 acknowledge
        cur_req = "R8";
        pulse_ack();
        rd(4, "R8", 32'h02000000);
        rd(0, "R8", 32'h80100008);
        chk("R9", 32'(irq_valid), 32'h0);

        // R9 nesting
        cur_req = "R9";
        pulse_done();
        chk("R10", 32'(irq_line), 32'd20);
        pulse_ack();
        chk("R9", 32'(irq_valid), 32'h0);
        wr(0, 32'h00000400);
        chk("R9", 32'(irq_valid), 32'h0);
        wr(0, 32'h02000000);
        chk("R9", 32'(irq_line), 32'd25);
        pulse_ack();
        rd(4, "R9", 32'h02100000);

        // R10 retire order
        cur_req = "R10";
        pulse_done();
        rd(4, "R10", 32'h00100000);
        chk("R10", 32'(irq_valid), 32'h0);
        pulse_done();
        rd(4, "R10", 32'h0);
        chk("R10", 32'(irq_line), 32'd10);
        do_reset();
        pulse_done();
        rd(4, "R10", 32'h0);

        // R11 held request
        cur_req = "R11";
        wr(2, 32'hFFFFFFFF);
        b_req = 32'h80; tick(); tick();
        pulse_ack();
        tick();
        rd(0, "R11", 32'h0);
        rd(4, "R11", 32'h80);
        pulse_done();
        rd(0, "R11", 32'h80);
        b_req = '0;

        // R12 simultaneous retire and take
        do_reset();
        cur_req = "R12";
        all_low_urgency();
        wr(0, 32'h10);
        pulse_ack();
        wr(8, 32'hC000C0C0);
        wr(0, 32'h04);
        chk("R12", 32'(irq_line), 32'd2);
        b_ack = 1; b_done = 1; tick(); b_ack = 0; b_done = 0;
        rd(4, "R12", 32'h04);

        // R13 unmapped words
        cur_req = "R13";
        wr(5, 32'hFFFFFFFF);
        wr(6, 32'hFFFFFFFF);
        wr(7, 32'hFFFFFFFF);
        rd(0, "R13", 32'h0);
        rd(2, "R13", 32'hFFFFFFFF);
        rd(5, "R13", 32'h0);
        rd(7, "R13", 32'h0);

        // Random mix against the model
        do_reset();
        cur_req = "R6";
        for (int n = 0; n < 4000; n++) begin
            b_req   = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : '0;
            b_ack   = ($urandom % 2 == 0);
            b_done  = ($urandom % 7 == 0);
            b_we    = ($urandom % 4 == 0);
            b_addr  = 4'($urandom % 16);
            b_wdata = $urandom;
            tick();
        end
        b_we = 0; b_ack = 0; b_done = 0; b_req = '0;
        tick();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule